// File: doc/BRIEF.md
# Two-Phase Block Copy Engine

This engine copies a run of 64-bit words from one region of a shared local memory to another on behalf of a controlling processor. The processor places a source word address, a destination word address and a byte count on the configuration pins and pulses `start`. The engine asks for the shared bus, and once the arbiter grants it, it moves one word at a time. Each word first goes from the source into an internal holding register, and then from that register to the destination.

There is a single channel, so only one copy can run at a time. Memory traffic uses plain strobes. A read strobe returns data in the same cycle, and the data is captured at the closing edge. `bus_gnt` is the only back-pressure. In any cycle where the grant is low, the engine drives no strobe and keeps its phase and addresses unchanged. When the copy ends, the engine drops its request and reports completion with a single-cycle `done`.

Top module: `dma_mover`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req`, `rd_en` and `wr_en` are all low.
- R2: `cfg_len` counts bytes. The number of words moved is the byte count divided by 8, rounded up. A count of 0 moves nothing: `done` pulses in the first cycle after `start` and no strobe is issued. Every destination word at or beyond the rounded count keeps its value.
- R3: Each word is read in one cycle and written in a later cycle. The written data equals the data captured by the most recent read. `rd_en` and `wr_en` are never high together, and two reads never occur back to back.
- R4: Word k (counting from 0) is read from `cfg_src + k` and written to `cfg_dst + k`, both taken modulo 2^AW. The address of each write is one above the address of the previous write in the same copy.
- R5: `bus_req` is high from the cycle after an accepted `start` until the cycle of the final write. A strobe occurs only in a cycle with `bus_gnt` and `bus_req` both high. While the grant is low, the engine stalls without losing progress.
- R6: If the grant is held high, N words take exactly 2N strobe cycles and `done` appears in cycle 2N+1 after `start`. For example, 1460 bytes is 183 words and takes 366 cycles.
- R7: `done` is high for exactly one cycle, right after the final write, and `bus_req` is low in that cycle. One cycle later `busy` is low.
- R8: A `start` that arrives while `busy` is high is ignored. The running copy is not changed and no second copy follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy; taken only when idle |
| cfg_src | input | AW | Source word address |
| cfg_dst | input | AW | Destination word address |
| cfg_len | input | LW | Copy length in bytes |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | Single-cycle completion pulse |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted; low stalls the engine |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | AW | Source word address being read |
| rd_data | input | DW | Source data, valid in the read cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination word address being written |
| wr_data | output | DW | Holding register contents |

## Verification
A corrupt word counter shows up as a wrong number of strobes, or as a `done` pulse whose position differs from cycle 2N+1 (or from 4N under an alternating grant). The bench detects this in the same transfer. A fault in the phase logic, such as a skipped read or a write without the grant, changes the destination contents or produces a strobe in a cycle where the grant is low; both are visible on the first word affected. A wrong address step leaves a misplaced word or overwrites the sentinel word just past the end of the destination region. A faulty start gate corrupts a region that should have stayed untouched.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + AW'(1);
  end
endmodule

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - CW'(1);
  end

  assign last = (left_q == CW'(1));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_mover_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic no_words,
  input  logic bus_gnt,
  input  logic last_word,
  output logic accept,
  output logic rd_fire,
  output logic wr_fire,
  output logic req,
  output logic busy,
  output logic done
);
  dma_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = no_words ? ST_DONE : ST_RD;
      ST_RD:   if (bus_gnt) st_d = ST_WR;
      ST_WR:   if (bus_gnt) st_d = last_word ? ST_DONE : ST_RD;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign accept  = (st_q == ST_IDLE) && start;
  assign rd_fire = (st_q == ST_RD) && bus_gnt;
  assign wr_fire = (st_q == ST_WR) && bus_gnt;
  assign req     = (st_q == ST_RD) || (st_q == ST_WR);
  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_DONE);
endmodule

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int AW = 12,
  parameter int DW = 64,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [LW-1:0] cfg_len,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BPW = DW / 8;
  localparam int SH  = $clog2(BPW);
  localparam int CW  = LW + 1 - SH;

  logic          accept, last_word, rd_fire, wr_fire;
  logic [LW:0]   len_sum;
  logic [CW-1:0] n_words;
  logic [DW-1:0] hold_q;

  assign len_sum = {1'b0, cfg_len} + (LW+1)'(BPW - 1);
  assign n_words = CW'(len_sum >> SH);

  dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .no_words(n_words == '0), .bus_gnt(bus_gnt), .last_word(last_word),
    .accept(accept), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .req(bus_req), .busy(busy), .done(done)
  );

  dma_word_ctr #(.CW(CW)) u_words (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(n_words),
    .dec(wr_fire), .last(last_word)
  );

  dma_addr_ctr #(.AW(AW)) u_src_ptr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_src),
    .step(rd_fire), .addr(rd_addr)
  );

  dma_addr_ctr #(.AW(AW)) u_dst_ptr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cfg_dst),
    .step(wr_fire), .addr(wr_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (rd_fire) hold_q <= rd_data;
  end

  assign rd_en   = rd_fire;
  assign wr_en   = wr_fire;
  assign wr_data = hold_q;
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int AW = 12,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);
  logic [DW-1:0] seen_data;
  logic [AW-1:0] prev_wr;
  logic          wr_before;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_data <= '0;
      prev_wr   <= '0;
      wr_before <= 1'b0;
    end else begin
      if (rd_en) seen_data <= rd_data;
      if (!busy || done) wr_before <= 1'b0;
      else if (wr_en) begin
        wr_before <= 1'b1;
        prev_wr   <= wr_addr;
      end
    end
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  assert_no_double_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_write_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == seen_data));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_before) |-> (wr_addr == prev_wr + AW'(1)));
  assert_strobe_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> (bus_gnt && bus_req));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind dma_mover dma_mover_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/dma_mover_tb.sv
`timescale 1ns/1ps
module dma_mover_tb;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam int LW = 16;
  localparam int MW = 1 << AW;
  localparam logic [DW-1:0] SENT = 64'hDEAD_BEEF_0BAD_F00D;
  localparam int NV = 7;
  // vector table: source, destination, byte length, grant mode
  localparam int V_SRC [NV] = '{0,   5,   10,   20, 1020, 50,  33};
  localparam int V_DST [NV] = '{100, 200, 300,  40, 600,  700, 800};
  localparam int V_LEN [NV] = '{8,   9,   1460, 24, 64,   15,  17};
  localparam int V_MOD [NV] = '{0,   0,   0,    1,  0,    1,   2};

  logic clk = 0, rst_n = 0, start = 0, bus_gnt = 0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [LW-1:0] cfg_len = '0;
  logic busy, done, bus_req, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic [DW-1:0] dst_mem [MW];
  logic clr = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(int a);
    return (64'(a) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  assign rd_data = pat(int'(rd_addr));

  always @(posedge clk) begin
    if (clr) for (int i = 0; i < MW; i++) dst_mem[i] <= SENT;
    else if (wr_en) dst_mem[wr_addr] <= wr_data;
  end

  dma_mover #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_len(cfg_len), .busy(busy), .done(done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(int s, int d, int len, int mode, bit inject);
    int nw, exp_done, c, done_c, rds, wrs, bad_gnt, req_at_done, req_first, bad;
    nw = (len + 7) / 8;
    exp_done = (nw == 0) ? 1 : (mode == 1) ? 4*nw : (mode == 2) ? 2*nw + 6 : 2*nw + 1;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    cfg_src = AW'(s); cfg_dst = AW'(d); cfg_len = LW'(len); start = 1;
    @(posedge clk);
    c = 0; done_c = -1; rds = 0; wrs = 0; bad_gnt = 0; req_at_done = 0; req_first = 0;
    while (done_c < 0 && c < 5000) begin
      @(negedge clk);
      c++;
      start = 0;
      if (inject && c == 2) begin
        start = 1; cfg_src = 10'd500; cfg_dst = 10'd900; cfg_len = 16'd64;
      end
      bus_gnt = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(c % 2) : (c > 5);
      #1;
      if (c == 1) req_first = bus_req;
      if (rd_en) rds++;
      if (wr_en) wrs++;
      if ((rd_en || wr_en) && !bus_gnt) bad_gnt++;
      if (done) begin done_c = c; req_at_done = bus_req; end
    end
    @(negedge clk); start = 0; bus_gnt = 0; #1;
    check(done_c == exp_done, "R6 done cycle", done_c, exp_done);
    check(rds == nw && wrs == nw, "R2 strobe count", rds + wrs, 2*nw);
    check(bad_gnt == 0, "R5 strobe without grant", bad_gnt, 0);
    if (nw > 0) check(req_first == 1, "R5 request after start", req_first, 1);
    check(req_at_done == 0, "R7 request in done cycle", req_at_done, 0);
    check(!done && !busy, "R7 idle after done", {done, busy}, 0);
    bad = 0;
    for (int i = 0; i < nw; i++)
      if (dst_mem[(d + i) % MW] !== pat((s + i) % MW)) bad++;
    check(bad == 0, "R3 R4 copied words", bad, 0);
    check(dst_mem[(d + nw) % MW] === SENT, "R2 word past end untouched",
          int'(dst_mem[(d + nw) % MW] != SENT), 0);
    if (inject)
      check(dst_mem[900] === SENT, "R8 ignored start left region alone",
            int'(dst_mem[900] != SENT), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !bus_req && !rd_en && !wr_en, "R1 reset outputs",
          {busy, done, bus_req, rd_en, wr_en}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(!busy && !bus_req, "R1 idle after reset release", {busy, bus_req}, 0);
    for (int v = 0; v < NV; v++)
      run_xfer(V_SRC[v], V_DST[v], V_LEN[v], V_MOD[v], 1'b0);
    run_xfer(7, 400, 0, 0, 1'b0);   // R2 zero length
    run_xfer(0, 100, 16, 0, 1'b1);  // R8 start while busy
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule